// File: doc/BRIEF.md
# GC Volatility Fault Dispatch Unit

This unit sits beside the address map of a tagged-memory processor and serves the garbage collector's write barrier. One map port is shared in time. It normally looks up the memory-data word. For a short fixed window after a memory read or write begins, it looks up the virtual memory address instead. During that window the unit stores the level-2 volatility field of the address's map entry. Once the map has returned to the data word, the stored field is compared with the live level-1 volatility field of the data word. The result is a fault bit that is raised when the data word points into a region at least as volatile as the region being written.

The two volatility codes rank regions in opposite directions. On level 1, code 00 is the most volatile. On level 2, code 11 is the most volatile. A dispatch microinstruction may fold the fault bit, the oldspace bit, or both into its dispatch address. Microcode uses this to branch to the handler that moves objects. The map RAMs and the handler routines are outside this block, and the map lookup results arrive as inputs.

Top module: `gcv_dispatch_unit`

## Requirements
- R1: When no access window is open, `map_sel_vma` is 0 and `map_addr` equals `md_data`, so a dispatch issued after the data register changes sees the map result for the new data.
- R2: A cycle with `acc_start` high opens a window. For exactly the next 2 cycles, `map_sel_vma` is 1 and `map_addr` equals `vma_addr`. After that the map returns to `md_data`.
- R3: An `acc_start` that arrives while a window is open restarts it, so the window ends 2 cycles after the last start.
- R4: Bits 34:33 of `l2_entry` are stored on the last cycle of a window, and only then. Outside that cycle the stored field holds its value.
- R5: Let c be `l1_entry[9:7]` and h the stored level-2 field. `gcv_fault` is 1 exactly when c[2] is 0 and (3 − c[1:0]) ≥ h. It is combinational from the live `l1_entry`.
- R6: Whenever `l1_entry` bit 9 is set, `gcv_fault` is 0, whatever the stored field holds.
- R7: When `uinst` bit 10 is 1, `gcv_fault` is ORed into bit 0 of `disp_addr`.
- R8: When `uinst` bit 11 is 1, `oldspace` is ORed into bit 0 of `disp_addr`.
- R9: `disp_addr` bits above bit 0 always equal `disp_base`. With `uinst` bits 10 and 11 both 0, `disp_addr` equals `disp_base`.
- R10: A synchronous active-high `rst` clears the stored level-2 field to 00 and returns the map to `md_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_start | input | 1 | A memory read or write begins this cycle |
| vma_addr | input | 25 | Virtual memory address register |
| md_data | input | 25 | Memory-data register (pointer part) |
| map_addr | output | 25 | Address presented to the map RAMs |
| map_sel_vma | output | 1 | 1 while the map is looking at the address register |
| l1_entry | input | 24 | Level-1 map lookup result; volatility code in bits 9:7 |
| l2_entry | input | 36 | Level-2 map lookup result; volatility code in bits 34:33 |
| uinst | input | 16 | Dispatch microinstruction; bit 10 selects the fault, bit 11 selects oldspace |
| disp_base | input | 12 | Dispatch address before modification |
| oldspace | input | 1 | Oldspace property of the data word |
| disp_addr | output | 12 | Dispatch address after ORing in the selected bits |
| gcv_fault | output | 1 | Volatility fault bit |

## Verification
On every cycle, the assertions check the map steering against the data register and the start strobe. They check that the stored field holds outside the capture cycle and takes bits 34:33 on it. They also check that reset clears state, that bit 9 of the level-1 code suppresses the fault, that the all-zero level-1 code always faults, and that the upper dispatch bits pass through. The full fault table can only be shown by the bench scenarios. The bench sweeps every stored field against every level-1 code, select pair and oldspace value. Only those scenarios show that the value stored comes from the last window cycle and not the first, and that a restarted window stores its own value.

// File: rtl/gcv_pkg.sv
package gcv_pkg;

  // Volatility fault: level-1 code c (00 = most volatile on its two low bits,
  // top bit set = never faults) against level-2 code h (11 = most volatile).
  // Fault when the level-1 rank is at least the level-2 rank.
  function automatic logic vol_fault(input logic [2:0] l1_code,
                                     input logic [1:0] l2_code);
    logic [1:0] l1_rank;
    if (l1_code[2]) begin
      return 1'b0;
    end
    l1_rank = 2'd3 - l1_code[1:0];
    return (l1_rank >= l2_code);
  endfunction

  // Bit folded into the dispatch address from the two select bits.
  function automatic logic disp_or_bit(input logic sel_fault,
                                       input logic sel_old,
                                       input logic fault,
                                       input logic old);
    return (sel_fault & fault) | (sel_old & old);
  endfunction

endpackage

// File: rtl/gcv_map_steer.sv
module gcv_map_steer #(
  parameter int ADDR_W     = 25,
  parameter int WIN_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_start,
  input  logic [ADDR_W-1:0] vma_addr,
  input  logic [ADDR_W-1:0] md_data,
  output logic [ADDR_W-1:0] map_addr,
  output logic              map_sel_vma,
  output logic              cap_strobe
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(WIN_CYCLES);
  localparam logic [CW-1:0] LAST_CYC = CW'(1);

  logic [CW-1:0] win_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
    end else if (acc_start) begin
      win_cnt <= WIN_LOAD;
    end else if (win_cnt != '0) begin
      win_cnt <= win_cnt - LAST_CYC;
    end
  end

  assign map_sel_vma = (win_cnt != '0);
  assign cap_strobe  = (win_cnt == LAST_CYC) && !acc_start;
  assign map_addr    = map_sel_vma ? vma_addr : md_data;

endmodule

// File: rtl/gcv_l2_latch.sv
module gcv_l2_latch #(
  parameter int L2_W   = 36,
  parameter int L2_LSB = 33
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_strobe,
  input  logic [L2_W-1:0] l2_entry,
  output logic [1:0]      held_vol
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_vol <= 2'b00;
    end else if (cap_strobe) begin
      held_vol <= l2_entry[L2_LSB +: 2];
    end
  end
endmodule

// File: rtl/gcv_fault_eval.sv
module gcv_fault_eval #(
  parameter int L1_W   = 24,
  parameter int L1_LSB = 7
) (
  input  logic [L1_W-1:0] l1_entry,
  input  logic [1:0]      held_vol,
  output logic            gcv_fault
);
  import gcv_pkg::*;

  logic [2:0] l1_code;

  assign l1_code   = l1_entry[L1_LSB +: 3];
  assign gcv_fault = vol_fault(l1_code, held_vol);
endmodule

// File: rtl/gcv_dispatch_merge.sv
module gcv_dispatch_merge #(
  parameter int UI_W       = 16,
  parameter int DISP_W     = 12,
  parameter int GCV_EN_BIT = 10,
  parameter int OLD_EN_BIT = 11
) (
  input  logic [UI_W-1:0]   uinst,
  input  logic [DISP_W-1:0] disp_base,
  input  logic              gcv_fault,
  input  logic              oldspace,
  output logic [DISP_W-1:0] disp_addr
);
  import gcv_pkg::*;

  logic or_bit;

  assign or_bit = disp_or_bit(uinst[GCV_EN_BIT], uinst[OLD_EN_BIT],
                              gcv_fault, oldspace);

  generate
    if (DISP_W > 1) begin : g_wide
      assign disp_addr = {disp_base[DISP_W-1:1], disp_base[0] | or_bit};
    end else begin : g_narrow
      assign disp_addr = disp_base | or_bit;
    end
  endgenerate
endmodule

// File: rtl/gcv_dispatch_unit.sv
module gcv_dispatch_unit #(
  parameter int ADDR_W     = 25,
  parameter int WIN_CYCLES = 2,
  parameter int L1_W       = 24,
  parameter int L1_LSB     = 7,
  parameter int L2_W       = 36,
  parameter int L2_LSB     = 33,
  parameter int UI_W       = 16,
  parameter int DISP_W     = 12,
  parameter int GCV_EN_BIT = 10,
  parameter int OLD_EN_BIT = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_start,
  input  logic [ADDR_W-1:0] vma_addr,
  input  logic [ADDR_W-1:0] md_data,
  output logic [ADDR_W-1:0] map_addr,
  output logic              map_sel_vma,
  input  logic [L1_W-1:0]   l1_entry,
  input  logic [L2_W-1:0]   l2_entry,
  input  logic [UI_W-1:0]   uinst,
  input  logic [DISP_W-1:0] disp_base,
  input  logic              oldspace,
  output logic [DISP_W-1:0] disp_addr,
  output logic              gcv_fault
);
  // Internal events named for the checker.
  logic       cap_strobe;
  logic [1:0] held_vol;

  gcv_map_steer #(
    .ADDR_W(ADDR_W), .WIN_CYCLES(WIN_CYCLES)
  ) u_steer (
    .clk(clk), .rst(rst), .acc_start(acc_start),
    .vma_addr(vma_addr), .md_data(md_data),
    .map_addr(map_addr), .map_sel_vma(map_sel_vma),
    .cap_strobe(cap_strobe)
  );

  gcv_l2_latch #(
    .L2_W(L2_W), .L2_LSB(L2_LSB)
  ) u_latch (
    .clk(clk), .rst(rst), .cap_strobe(cap_strobe),
    .l2_entry(l2_entry), .held_vol(held_vol)
  );

  gcv_fault_eval #(
    .L1_W(L1_W), .L1_LSB(L1_LSB)
  ) u_eval (
    .l1_entry(l1_entry), .held_vol(held_vol), .gcv_fault(gcv_fault)
  );

  gcv_dispatch_merge #(
    .UI_W(UI_W), .DISP_W(DISP_W),
    .GCV_EN_BIT(GCV_EN_BIT), .OLD_EN_BIT(OLD_EN_BIT)
  ) u_merge (
    .uinst(uinst), .disp_base(disp_base),
    .gcv_fault(gcv_fault), .oldspace(oldspace),
    .disp_addr(disp_addr)
  );

endmodule

// File: rtl/gcv_checker.sv
module gcv_checker #(
  parameter int ADDR_W     = 25,
  parameter int WIN_CYCLES = 2,
  parameter int L1_W       = 24,
  parameter int L1_LSB     = 7,
  parameter int L2_W       = 36,
  parameter int L2_LSB     = 33,
  parameter int UI_W       = 16,
  parameter int DISP_W     = 12,
  parameter int GCV_EN_BIT = 10,
  parameter int OLD_EN_BIT = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_start,
  input logic [ADDR_W-1:0] md_data,
  input logic [ADDR_W-1:0] map_addr,
  input logic              map_sel_vma,
  input logic [L1_W-1:0]   l1_entry,
  input logic [L2_W-1:0]   l2_entry,
  input logic [UI_W-1:0]   uinst,
  input logic [DISP_W-1:0] disp_base,
  input logic [DISP_W-1:0] disp_addr,
  input logic              gcv_fault,
  input logic              cap_strobe,
  input logic [1:0]        held_vol
);

  assert_idle_md_R1: assert property (@(posedge clk) disable iff (rst)
    !map_sel_vma |-> map_addr == md_data);

  assert_win_open_R2: assert property (@(posedge clk) disable iff (rst)
    acc_start |=> map_sel_vma);

  assert_win_second_R2: assert property (@(posedge clk) disable iff (rst)
    acc_start ##1 !acc_start |=> map_sel_vma);

  generate
    if (WIN_CYCLES == 2) begin : g_two
      assert_win_close_R2: assert property (@(posedge clk) disable iff (rst)
        acc_start ##1 !acc_start ##1 !acc_start |=> !map_sel_vma);
      // R3: a restart inside the window keeps it open two more cycles
      assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
        acc_start ##1 acc_start ##1 !acc_start |=> map_sel_vma);
    end
  endgenerate

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    cap_strobe |=> held_vol == $past(l2_entry[L2_LSB +: 2]));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !cap_strobe |=> $stable(held_vol));

  assert_most_volatile_R5: assert property (@(posedge clk) disable iff (rst)
    l1_entry[L1_LSB +: 3] == 3'b000 |-> gcv_fault);

  assert_bit9_masks_R6: assert property (@(posedge clk) disable iff (rst)
    l1_entry[L1_LSB + 2] |-> !gcv_fault);

  assert_fault_or_R7: assert property (@(posedge clk) disable iff (rst)
    (uinst[GCV_EN_BIT] && gcv_fault) |-> disp_addr[0]);

  assert_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (!uinst[GCV_EN_BIT] && !uinst[OLD_EN_BIT]) |-> disp_addr == disp_base);

  assert_upper_R9: assert property (@(posedge clk) disable iff (rst)
    (disp_addr >> 1) == (disp_base >> 1));

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (held_vol == 2'b00) && !map_sel_vma);

endmodule

bind gcv_dispatch_unit gcv_checker #(
  .ADDR_W(ADDR_W), .WIN_CYCLES(WIN_CYCLES), .L1_W(L1_W), .L1_LSB(L1_LSB),
  .L2_W(L2_W), .L2_LSB(L2_LSB), .UI_W(UI_W), .DISP_W(DISP_W),
  .GCV_EN_BIT(GCV_EN_BIT), .OLD_EN_BIT(OLD_EN_BIT)
) u_chk (
  .clk(clk), .rst(rst), .acc_start(acc_start), .md_data(md_data),
  .map_addr(map_addr), .map_sel_vma(map_sel_vma), .l1_entry(l1_entry),
  .l2_entry(l2_entry), .uinst(uinst), .disp_base(disp_base),
  .disp_addr(disp_addr), .gcv_fault(gcv_fault),
  .cap_strobe(cap_strobe), .held_vol(held_vol)
);

// File: tb/sim_gcv_dispatch_unit.sv
`timescale 1ns/1ps
module sim_gcv_dispatch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_start = 1'b0;
  logic [24:0] vma_addr = 25'h1ABCDEF;
  logic [24:0] md_data  = 25'h0123456;
  logic [23:0] l1_entry = 24'hFFFFFF;
  logic [35:0] l2_entry = '0;
  logic [15:0] uinst = '0;
  logic [11:0] disp_base = 12'hA5A;
  logic        oldspace = 1'b0;
  logic [24:0] map_addr;
  logic        map_sel_vma;
  logic [11:0] disp_addr;
  logic        gcv_fault;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gcv_dispatch_unit u0 (
    .clk(clk), .rst(rst), .acc_start(acc_start),
    .vma_addr(vma_addr), .md_data(md_data),
    .map_addr(map_addr), .map_sel_vma(map_sel_vma),
    .l1_entry(l1_entry), .l2_entry(l2_entry), .uinst(uinst),
    .disp_base(disp_base), .oldspace(oldspace),
    .disp_addr(disp_addr), .gcv_fault(gcv_fault)
  );

  // Fault from the ranking rule: sum of low level-1 bits and level-2 code
  // at most 3, with level-1 codes 4..7 never faulting.
  function automatic logic ref_fault(input int c, input int h);
    return (c < 4) && (((c % 4) + h) <= 3);
  endfunction

  function automatic logic [23:0] l1_word(input int c);
    logic [23:0] w;
    w = 24'hFFFFFF;
    w[9:7] = 3'(c);
    return w;
  endfunction

  function automatic logic [35:0] l2_word(input int h);
    logic [35:0] w;
    w = 36'hF_FFFF_FFFF;
    w[34:33] = 2'(h);
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Runs one access; the first window cycle offers h_early, the last h_late.
  task automatic do_access(input int h_early, input int h_late);
    acc_start = 1'b1;
    step();
    acc_start = 1'b0;
    l2_entry = l2_word(h_early);
    #1;
    chk("R2 sel first cycle", {31'd0, map_sel_vma}, 32'd1);
    chk("R2 vma on map", {7'd0, map_addr}, {7'd0, vma_addr});
    step();
    l2_entry = l2_word(h_late);
    #1;
    chk("R2 sel last cycle", {31'd0, map_sel_vma}, 32'd1);
    step();
    l2_entry = l2_word(3 - h_late);
    #1;
    chk("R2 window closed", {31'd0, map_sel_vma}, 32'd0);
    chk("R1 md on map", {7'd0, map_addr}, {7'd0, md_data});
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    #1;
    // R10: stored field 00, so code 011 (least volatile rank) still faults
    chk("R10 sel after reset", {31'd0, map_sel_vma}, 32'd0);
    chk("R1 map follows md", {7'd0, map_addr}, {7'd0, md_data});
    l1_entry = l1_word(3);
    #1;
    chk("R10 held field 00", {31'd0, gcv_fault}, 32'd1);

    // R1: data register change seen at once by the map
    md_data = 25'h0FEDCBA;
    #1;
    chk("R1 new md on map", {7'd0, map_addr}, {7'd0, md_data});

    // R4/R5/R6/R7/R8/R9: sweep all stored fields against all inputs
    for (int h = 0; h < 4; h++) begin
      do_access(3 - h, h);
      for (int c = 0; c < 8; c++) begin
        l1_entry = l1_word(c);
        for (int s = 0; s < 4; s++) begin
          for (int o = 0; o < 2; o++) begin
            logic f;
            logic [11:0] e;
            uinst = 16'h53FF | 16'(s << 10);
            oldspace = o[0];
            disp_base = (c % 2 == 0) ? 12'hA5A : 12'h3C5;
            f = ref_fault(c, h);
            e = disp_base | 12'(((s % 2) & int'(f)) | ((s / 2) & o));
            #1;
            if (c >= 4)
              chk("R6 bit9 masks fault", {31'd0, gcv_fault}, 32'd0);
            else
              chk("R5 fault table", {31'd0, gcv_fault}, {31'd0, f});
            if (s == 0)
              chk("R9 pass through", {20'd0, disp_addr}, {20'd0, disp_base});
            else if (s == 1)
              chk("R7 fault ORed", {20'd0, disp_addr}, {20'd0, e});
            else
              chk("R8 oldspace ORed", {20'd0, disp_addr}, {20'd0, e});
          end
        end
      end
    end

    // R4: field holds while idle even as l2_entry changes (stored h=3)
    l1_entry = l1_word(1);
    for (int k = 0; k < 4; k++) begin
      l2_entry = l2_word(k);
      step();
      #1;
      chk("R4 field holds", {31'd0, gcv_fault}, 32'd0);
    end

    // R3: restart inside the window; stored value from the restarted window
    acc_start = 1'b1;
    l2_entry = l2_word(0);
    step();
    l2_entry = l2_word(0);
    step();
    acc_start = 1'b0;
    l2_entry = l2_word(0);
    #1;
    chk("R3 open after restart", {31'd0, map_sel_vma}, 32'd1);
    step();
    l2_entry = l2_word(3);
    #1;
    chk("R3 still open", {31'd0, map_sel_vma}, 32'd1);
    step();
    l2_entry = l2_word(0);
    #1;
    chk("R3 closed", {31'd0, map_sel_vma}, 32'd0);
    chk("R3 restarted capture", {31'd0, gcv_fault}, 32'd0);

    // R5: live level-1 code changes the fault in the same cycle
    l1_entry = l1_word(0);
    #1;
    chk("R5 live l1", {31'd0, gcv_fault}, 32'd1);

    // R10: reset mid-run after storing 3
    rst = 1'b1;
    step();
    rst = 1'b0;
    l1_entry = l1_word(3);
    #1;
    chk("R10 reset clears field", {31'd0, gcv_fault}, 32'd1);
    chk("R10 reset map select", {31'd0, map_sel_vma}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule